// File: doc/BRIEF.md
# Prescaled Multi-Channel Down-Counter Timer

The unit holds several independent down-counters that share one prescaler. The prescaler counts clock cycles and issues a single-cycle tick each time it passes through zero. On each tick, every enabled channel decrements its counter. When a channel sees a tick while its counter is at zero, it underflows and pulses its interrupt line. After an underflow the channel either restarts from its preset or stops and clears its own enable bit.

Software reaches the unit through a flat register port with a write strobe, a word address, write data and combinational read data. Any write updates the addressed register at the next rising clock edge. The upper address bits select a region, and the two low bits select a register within that region. Region 0 holds the prescaler. Region c+1 holds channel c.

Top module: `tmr_unit`

## Requirements
- R1: Address map, word addressed, with region = addr_i[AW-1:2] and sel = addr_i[1:0]. In region 0, sel 0 reads the prescaler's current value and sel 1 is the prescaler reload. In region c+1, sel 0 is channel c's counter (read/write), sel 1 is its preset and sel 2 is its control. The control bits are: bit 0 enable, bit 1 reload-at-zero, bit 2 load.
- R2: A write of a prescaler reload below N_CH stores N_CH. Any other value is stored as written. The stored reload is never below N_CH.
- R3: While at least one channel is enabled, the prescaler counts down by one each clock. Its tick is asserted for the one cycle in which its value is zero, and on that edge it reloads. The tick period is therefore reload+1 cycles. While no channel is enabled, the prescaler value holds.
- R4: An enabled channel's counter decrements by one on each prescaler tick.
- R5: A channel whose enable bit is 0 holds its counter.
- R6: A tick that arrives while an enabled channel's counter is zero is an underflow. The channel's irq_o bit goes high for exactly one cycle, starting at that edge.
- R7: On underflow with reload-at-zero set to 1, the counter takes the preset value and the channel stays enabled.
- R8: On underflow with reload-at-zero set to 0, the counter stays at zero and the channel's enable bit clears.
- R9: Writing control with bit 2 set copies the channel's preset into its counter. This load wins over a decrement on the same edge. Bit 2 always reads back as 0.
- R10: After reset, all control bits, counters and presets are 0, the prescaler value and reload are both N_CH, and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | AW | Word address |
| wdata_i | input | CW | Write data |
| rdata_o | output | CW | Read data for addr_i (combinational) |
| irq_o | output | N_CH | Per-channel underflow pulse |

## Verification
Reads are combinational, and a write is visible after one edge. The bench therefore samples read data at the falling edge right after a write, and counts every write as exactly one rising edge. The prescaler is held at its reset value until a channel is first enabled. With the default reload of 4, the first tick falls on the fifth edge after the enabling write, and later ticks fall every reload+1 edges. An interrupt appears on the edge of the underflowing tick. Every directed test starts from reset so that this phase is known. The bench then sweeps edge by edge and checks irq_o on the exact edge it predicts, and also on every other edge in the window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CTL_EN = 0;
  localparam int unsigned CTL_RL = 1;
  localparam int unsigned CTL_LD = 2;

  localparam logic [1:0] SEL_PVAL = 2'd0;
  localparam logic [1:0] SEL_PRLD = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd0;
  localparam logic [1:0] SEL_RLD  = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PSW  = 16,
  parameter int unsigned N_CH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           rld_we_i,
  input  logic [PSW-1:0] rld_wdata_i,
  output logic           tick_o,
  output logic [PSW-1:0] val_o,
  output logic [PSW-1:0] rld_o
);
  localparam logic [PSW-1:0] FLOOR = PSW'(N_CH);

  logic [PSW-1:0] val_q, rld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= FLOOR;
      rld_q <= FLOOR;
    end else begin
      if (rld_we_i) rld_q <= (rld_wdata_i < FLOOR) ? FLOOR : rld_wdata_i;
      if (run_i) val_q <= (val_q == '0) ? rld_q : val_q - 1'b1;
    end
  end

  assign tick_o = run_i && (val_q == '0);
  assign val_o  = val_q;
  assign rld_o  = rld_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          we_cnt_i,
  input  logic          we_rld_i,
  input  logic          we_ctl_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] rld_o,
  output logic [CW-1:0] ctl_o,
  output logic          en_o,
  output logic          irq_o
);
  logic [CW-1:0] cnt_q, rld_q;
  logic          en_q, rl_q, irq_q, unf;

  assign unf = tick_i && en_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
      en_q  <= 1'b0;
      rl_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= unf;
      if (we_rld_i) rld_q <= wdata_i;
      if (we_ctl_i) begin
        en_q <= wdata_i[CTL_EN];
        rl_q <= wdata_i[CTL_RL];
      end else if (unf && !rl_q) begin
        en_q <= 1'b0;
      end
      // load strobe beats direct write and decrement
      if (we_ctl_i && wdata_i[CTL_LD]) cnt_q <= rld_q;
      else if (we_cnt_i)               cnt_q <= wdata_i;
      else if (tick_i && en_q) begin
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        else if (rl_q)   cnt_q <= rld_q;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign ctl_o = {{(CW-2){1'b0}}, rl_q, en_q};
  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH = 4,
  parameter int unsigned CW   = 32,
  parameter int unsigned PSW  = 16,
  parameter int unsigned AW   = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [CW-1:0]   wdata_i,
  output logic [CW-1:0]   rdata_o,
  output logic [N_CH-1:0] irq_o
);
  localparam int unsigned RW = AW - 2;

  logic [RW-1:0]             region;
  logic [1:0]                sel;
  logic                      psc_tick;
  logic [PSW-1:0]            psc_val, psc_rld;
  logic [N_CH-1:0]           en_vec;
  logic [N_CH-1:0][CW-1:0]   cnt_vec, rld_vec, ctl_vec;

  assign region = addr_i[AW-1:2];
  assign sel    = addr_i[1:0];

  tmr_prescaler #(.PSW(PSW), .N_CH(N_CH)) u_psc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (|en_vec),
    .rld_we_i    (we_i && region == '0 && sel == SEL_PRLD),
    .rld_wdata_i (wdata_i[PSW-1:0]),
    .tick_o      (psc_tick),
    .val_o       (psc_val),
    .rld_o       (psc_rld)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [RW-1:0] RID = RW'(c + 1);
    logic hit;
    assign hit = we_i && (region == RID);

    tmr_channel #(.CW(CW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (psc_tick),
      .we_cnt_i (hit && sel == SEL_CNT),
      .we_rld_i (hit && sel == SEL_RLD),
      .we_ctl_i (hit && sel == SEL_CTL),
      .wdata_i  (wdata_i),
      .cnt_o    (cnt_vec[c]),
      .rld_o    (rld_vec[c]),
      .ctl_o    (ctl_vec[c]),
      .en_o     (en_vec[c]),
      .irq_o    (irq_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (region == '0) begin
      if (sel == SEL_PVAL)      rdata_o = {{(CW-PSW){1'b0}}, psc_val};
      else if (sel == SEL_PRLD) rdata_o = {{(CW-PSW){1'b0}}, psc_rld};
    end
    for (int c = 0; c < N_CH; c++) begin
      if (region == RW'(c + 1)) begin
        case (sel)
          SEL_CNT: rdata_o = cnt_vec[c];
          SEL_RLD: rdata_o = rld_vec[c];
          SEL_CTL: rdata_o = ctl_vec[c];
          default: rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int unsigned N_CH = 4,
  parameter int unsigned CW   = 32,
  parameter int unsigned PSW  = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    we_i,
  input logic [N_CH-1:0]         irq_o,
  input logic                    psc_tick,
  input logic [PSW-1:0]          psc_rld,
  input logic [N_CH-1:0]         en_vec,
  input logic [N_CH-1:0][CW-1:0] cnt_vec
);
  a_r2_reload_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psc_rld >= PSW'(N_CH));

  a_r3_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psc_tick |=> !psc_tick);

  for (genvar c = 0; c < N_CH; c++) begin : g_a
    a_r6_irq_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> $past(psc_tick));

    a_r6_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |=> !irq_o[c]);

    a_r5_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_vec[c] && !we_i) |=> $stable(cnt_vec[c]));
  end
endmodule

bind tmr_unit tmr_unit_chk #(.N_CH(N_CH), .CW(CW), .PSW(PSW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .irq_o    (irq_o),
  .psc_tick (psc_tick),
  .psc_rld  (psc_rld),
  .en_vec   (en_vec),
  .cnt_vec  (cnt_vec)
);

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  tmr_unit dut (.*);

  always #10 clk_i = ~clk_i;

  typedef struct packed {
    logic        we;
    logic [5:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{1'b1, 6'd1,  32'd2,          32'd4,          8'd2},  // R2 clamp
    '{1'b1, 6'd1,  32'd9,          32'd9,          8'd2},
    '{1'b1, 6'd1,  32'd4,          32'd4,          8'd2},  // R2 at floor
    '{1'b1, 6'd5,  32'h1234,       32'h1234,       8'd1},  // R1 preset
    '{1'b1, 6'd6,  32'd4,          32'd0,          8'd9},  // R9 load reads 0
    '{1'b0, 6'd4,  32'd0,          32'h1234,       8'd9},  // R9 copy
    '{1'b1, 6'd10, 32'd2,          32'd2,          8'd1},
    '{1'b1, 6'd10, 32'd6,          32'd2,          8'd9},
    '{1'b1, 6'd8,  32'hFFFF_FFFF,  32'hFFFF_FFFF,  8'd1},
    '{1'b0, 6'd0,  32'd0,          32'd4,          8'd3}   // R3 held
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    step(2);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int first, hits, second, stray;

    // R10 reset state
    do_reset();
    for (int c = 0; c < 4; c++) begin
      rd(6'((c + 1) * 4 + 2), v); check("R10 ctl", v, 32'd0);
      rd(6'((c + 1) * 4), v);     check("R10 cnt", v, 32'd0);
    end
    rd(6'd1, v); check("R10 psc reload", v, 32'd4);
    rd(6'd0, v); check("R10 psc value", v, 32'd4);
    check("R10 irq", {28'd0, irq_o}, 32'd0);

    // table walk
    for (int i = 0; i < 10; i++) begin
      if (TBL[i].we) wr(TBL[i].addr, TBL[i].wd);
      rd(TBL[i].addr, v);
      check($sformatf("R%0d table %0d", TBL[i].req, i), v, TBL[i].exp);
    end

    // one-shot: R4 R6 R8
    do_reset();
    wr(6'd5, 32'd3); wr(6'd6, 32'd4); wr(6'd6, 32'd1);
    first = 0; hits = 0;
    for (int k = 1; k <= 25; k++) begin
      step(1);
      if (irq_o[0]) begin hits++; if (first == 0) first = k; end
      if (k == 10) begin rd(6'd4, v); check("R4 count after two ticks", v, 32'd1); end
    end
    check("R6 irq edge", first, 20);
    check("R6 irq single pulse", hits, 1);
    rd(6'd6, v); check("R8 enable cleared", v, 32'd0);
    rd(6'd4, v); check("R8 count stays zero", v, 32'd0);

    // periodic: R7
    do_reset();
    wr(6'd9, 32'd1); wr(6'd10, 32'd4); wr(6'd10, 32'd3);
    first = 0; second = 0; hits = 0;
    for (int k = 1; k <= 25; k++) begin
      step(1);
      if (irq_o[1]) begin
        hits++;
        if (first == 0) first = k; else second = k;
      end
    end
    check("R7 irq count", hits, 2);
    check("R7 first irq", first, 10);
    check("R7 second irq", second, 20);
    rd(6'd10, v); check("R7 stays enabled", v, 32'd3);

    // hold: R5 R3
    do_reset();
    wr(6'd5, 32'd100); wr(6'd6, 32'd4); wr(6'd6, 32'd1);
    step(12);
    wr(6'd6, 32'd0);
    step(20);
    rd(6'd4, v); check("R5 count held", v, 32'd98);
    rd(6'd0, v); check("R3 psc held", v, 32'd1);

    // load priority: R9
    do_reset();
    wr(6'd5, 32'd50); wr(6'd4, 32'd10); wr(6'd6, 32'd1);
    step(4);
    wr(6'd6, 32'd5);
    rd(6'd4, v); check("R9 load beats decrement", v, 32'd50);
    rd(6'd6, v); check("R9 load bit reads 0", v, 32'd1);

    // shared prescaler: R3 R6
    do_reset();
    wr(6'd1, 32'd9); wr(6'd4, 32'd1); wr(6'd12, 32'd1);
    wr(6'd6, 32'd1);
    wr(6'd14, 32'd1);
    stray = 0; hits = 0;
    for (int k = 2; k <= 20; k++) begin
      step(1);
      if (k == 15) begin
        if (irq_o == 4'b0101) hits++;
      end else if (irq_o != 4'b0000) stray++;
    end
    check("R3 shared tick irq", hits, 1);
    check("R6 no stray irq", stray, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule